// File: doc/BRIEF.md
# Dual Window Supply Monitor Logic

This block is the digital back end of a supervisor that watches two supplies, each against a window with a lower and an upper limit. For each pair, analog comparators outside the block supply two levels. One says the supply is above the lower limit. The other says it is above the upper limit. The block turns these levels into three outputs per pair:

- an undervoltage status that is high when the supply is healthy;
- an overvoltage status that is high when the supply is healthy;
- a pair power-good.

The comparator levels are synchronised. Short transients are then filtered out. The undervoltage status must see a long, continuous stretch of good input before it rises.

The two statuses have opposite starting points. The overvoltage status comes up high as soon as the pair is allowed to report, and it falls only on a filtered overvoltage. The undervoltage status starts low and waits out the stability delay. Power-good for a pair is high only while both statuses are high. A shared bias-valid input forces every output low. Each pair also has its own enable, which forces that pair's outputs low and restarts its timing.

Filter and stability times are counted in clock cycles and set by parameters.

Top module: `dwm_window_mon`

## Requirements
- R1: While `rst` is high at a clock edge, every status and power-good output is low after that edge.
- R2: While `bias_ok` is low, every output is low one edge later, whatever the comparator and enable inputs do.
- R3: On the first edge with `bias_ok` high and the pair's enable high, the pair's overvoltage status goes high, and its undervoltage status and power-good stay low.
- R4: The undervoltage status rises only after the synchronised lower-limit level has been high for `STAB_CYC` consecutive edges. Counted from a bias or enable release, it rises on edge `STAB_CYC`+1. Counted from an input change, it rises on edge `STAB_CYC`+3, which covers two synchroniser flops and one output register.
- R5: A pair's power-good is high exactly when both of its statuses are high.
- R6: If the lower-limit level stays low for `FILT_CYC` consecutive synchronised cycles, the undervoltage status and that pair's power-good fall on edge `FILT_CYC`+3 after the input change.
- R7: If the upper-limit level stays high for `FILT_CYC` synchronised cycles, the overvoltage status and power-good fall on edge `FILT_CYC`+3, and the undervoltage status keeps its value.
- R8: After an overvoltage clears, the overvoltage status returns high on edge `FILT_CYC`+3, and power-good returns with it if the undervoltage status is high.
- R9: A violation on either comparator that lasts fewer than `FILT_CYC` cycles changes no output.
- R10: Driving a pair's enable low forces all three of its outputs low on the next edge. Raising the enable restarts the pair as in R3 and R4.
- R11: Each pair's outputs depend only on its own comparators and enable. Events on one pair leave the other pair's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bias_ok | input | 1 | Bias valid; when low, all outputs are forced low |
| en | input | NPAIR | Per-pair monitoring enable |
| uv_cmp | input | NPAIR | Per-pair comparator level: supply above lower limit |
| ov_cmp | input | NPAIR | Per-pair comparator level: supply above upper limit |
| uv_stat | output | NPAIR | Per-pair undervoltage status, high when the lower limit is satisfied |
| ov_stat | output | NPAIR | Per-pair overvoltage status, high when the upper limit is not exceeded |
| pwr_ok | output | NPAIR | Per-pair power-good, high when the supply is inside its window |

## Verification
On one pair, the undervoltage stability count can complete on the same edge as the overvoltage filter flips. The bench provokes this by re-enabling the pair and then raising the upper-limit level exactly `STAB_CYC`-`FILT_CYC`-2 cycles later. On that edge the undervoltage status must rise, the overvoltage status must fall and power-good must stay low. When the overvoltage is later released, power-good must return. The bench also lands events on both pairs in overlapping windows, so that each pair's outputs can be judged against that pair alone.

// File: rtl/dwm_pkg.sv
package dwm_pkg;
  // Output bundle of one monitored pair
  typedef struct packed {
    logic uv_ok;
    logic ov_ok;
    logic pg;
  } pair_out_t;

  function automatic int max_int(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dwm_sync.sv
module dwm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dwm_qualify.sv
// Level qualifier: the held level follows the input only after the input has
// disagreed with it for a run of consecutive cycles. The run length depends on
// the direction of the change.
module dwm_qualify
  import dwm_pkg::*;
#(
  parameter int RISE_CYC = 4,
  parameter int FALL_CYC = 4,
  parameter bit INIT     = 1'b0
) (
  input  logic clk,
  input  logic clr,
  input  logic in_lvl,
  output logic lvl_q
);
  localparam int LMAX = max_int(RISE_CYC, FALL_CYC);
  localparam int CW   = $clog2(LMAX + 1);
  localparam logic [CW-1:0] RISE_LAST = CW'(RISE_CYC - 1);
  localparam logic [CW-1:0] FALL_LAST = CW'(FALL_CYC - 1);

  logic [CW-1:0] run_cnt;
  logic [CW-1:0] last;

  assign last = lvl_q ? FALL_LAST : RISE_LAST;

  always_ff @(posedge clk) begin
    if (clr) begin
      lvl_q   <= INIT;
      run_cnt <= '0;
    end else if (in_lvl == lvl_q) begin
      run_cnt <= '0;
    end else if (run_cnt == last) begin
      lvl_q   <= in_lvl;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + CW'(1);
    end
  end

  AST_FLIP_NEEDS_RUN: assert property (@(posedge clk) disable iff (clr)
    (run_cnt != last) |=> $stable(lvl_q)); // R9
  AST_AGREE_RESTARTS_RUN: assert property (@(posedge clk) disable iff (clr)
    (in_lvl == lvl_q) |=> (run_cnt == '0)); // R4
endmodule

// File: rtl/dwm_pair.sv
module dwm_pair
  import dwm_pkg::*;
#(
  parameter int FILT_CYC = 6,
  parameter int STAB_CYC = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic uv_lvl,
  input  logic ov_lvl,
  output logic uv_stat,
  output logic ov_stat,
  output logic pwr_ok
);
  logic clr;
  logic uv_q, ovf_q;
  pair_out_t nxt;

  assign clr = rst | hold;

  // Lower limit: slow qualify on the way up, glitch filter on the way down
  dwm_qualify #(.RISE_CYC(STAB_CYC), .FALL_CYC(FILT_CYC), .INIT(1'b0)) u_uv (
    .clk(clk), .clr(clr), .in_lvl(uv_lvl), .lvl_q(uv_q));

  // Upper limit: qualified "not over", glitch filter in both directions
  dwm_qualify #(.RISE_CYC(FILT_CYC), .FALL_CYC(FILT_CYC), .INIT(1'b1)) u_ov (
    .clk(clk), .clr(clr), .in_lvl(~ov_lvl), .lvl_q(ovf_q));

  always_comb begin
    nxt.uv_ok = uv_q;
    nxt.ov_ok = ovf_q;
    nxt.pg    = uv_q & ovf_q;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      uv_stat <= 1'b0;
      ov_stat <= 1'b0;
      pwr_ok  <= 1'b0;
    end else begin
      uv_stat <= nxt.uv_ok;
      ov_stat <= nxt.ov_ok;
      pwr_ok  <= nxt.pg;
    end
  end

  AST_PG_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    pwr_ok |-> (uv_stat && ov_stat)); // R5
  AST_HOLD_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!uv_stat && !ov_stat && !pwr_ok)); // R10
endmodule

// File: rtl/dwm_window_mon.sv
module dwm_window_mon #(
  parameter int NPAIR       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 1500,
  parameter int STAB_CYC    = 8000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bias_ok,
  input  logic [NPAIR-1:0] en,
  input  logic [NPAIR-1:0] uv_cmp,
  input  logic [NPAIR-1:0] ov_cmp,
  output logic [NPAIR-1:0] uv_stat,
  output logic [NPAIR-1:0] ov_stat,
  output logic [NPAIR-1:0] pwr_ok
);
  localparam int SW = 2 * NPAIR;

  logic [SW-1:0] cmp_s;

  dwm_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({ov_cmp, uv_cmp}), .q(cmp_s));

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    dwm_pair #(.FILT_CYC(FILT_CYC), .STAB_CYC(STAB_CYC)) u_pair (
      .clk    (clk),
      .rst    (rst),
      .hold   (~bias_ok | ~en[g]),
      .uv_lvl (cmp_s[g]),
      .ov_lvl (cmp_s[NPAIR + g]),
      .uv_stat(uv_stat[g]),
      .ov_stat(ov_stat[g]),
      .pwr_ok (pwr_ok[g]));

    AST_ENABLE_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
      !en[g] |=> (!uv_stat[g] && !ov_stat[g] && !pwr_ok[g])); // R10
  end

  AST_BIAS_LOW_ALL_LOW: assert property (@(posedge clk) disable iff (rst)
    !bias_ok |=> (uv_stat == '0 && ov_stat == '0 && pwr_ok == '0)); // R2
  AST_RESET_ALL_LOW: assert property (@(posedge clk)
    rst |=> (uv_stat == '0 && ov_stat == '0 && pwr_ok == '0)); // R1
endmodule

// File: tb/sim_dwm_window_mon.sv
module sim_dwm_window_mon;
  localparam int NP = 2;
  localparam int F  = 6;
  localparam int S  = 30;

  logic clk = 1'b0;
  logic rst, bias_ok;
  logic [NP-1:0] en, uv_cmp, ov_cmp;
  logic [NP-1:0] uv_stat, ov_stat, pwr_ok;

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;

  typedef struct {
    int    at;
    int    pair;
    logic  uv;
    logic  ov;
    logic  pg;
    string tag;
  } exp_t;
  exp_t sbq[$];

  dwm_window_mon #(.NPAIR(NP), .SYNC_STAGES(2), .FILT_CYC(F), .STAB_CYC(S)) u0 (
    .clk(clk), .rst(rst), .bias_ok(bias_ok), .en(en),
    .uv_cmp(uv_cmp), .ov_cmp(ov_cmp),
    .uv_stat(uv_stat), .ov_stat(ov_stat), .pwr_ok(pwr_ok));

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side: queue an expected output state d edges from now
  task automatic expect_at(int d, int p, logic u, logic o, logic g, string tag);
    exp_t e;
    e.at = cyc + d; e.pair = p; e.uv = u; e.ov = o; e.pg = g; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Monitor: compare due items away from the active edge
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].at == cyc) begin
        n_vec++;
        if (uv_stat[sbq[i].pair] !== sbq[i].uv || ov_stat[sbq[i].pair] !== sbq[i].ov ||
            pwr_ok[sbq[i].pair] !== sbq[i].pg) begin
          n_bad++;
          $display("FAIL %s pair %0d cyc %0d: got uv=%b ov=%b pg=%b expected uv=%b ov=%b pg=%b",
                   sbq[i].tag, sbq[i].pair, cyc, uv_stat[sbq[i].pair], ov_stat[sbq[i].pair],
                   pwr_ok[sbq[i].pair], sbq[i].uv, sbq[i].ov, sbq[i].pg);
        end
        sbq.delete(i);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc >= 5000) begin
      n_bad++;
      $display("FAIL watchdog: run hung at cyc %0d, expected completion", cyc);
      report();
    end
  end

  initial begin
    rst = 1'b1; bias_ok = 1'b0; en = '1; uv_cmp = '0; ov_cmp = '0;
    step(3);
    // R1: reset state
    expect_at(1, 0, 0, 0, 0, "R1");
    expect_at(1, 1, 0, 0, 0, "R1");
    step(2);
    rst = 1'b0;
    uv_cmp = '1;
    step(6);
    // R2: bias invalid holds everything low even with good inputs
    expect_at(1, 0, 0, 0, 0, "R2");
    expect_at(1, 1, 0, 0, 0, "R2");
    step(2);

    // R3/R4/R5: bias up
    bias_ok = 1'b1;
    expect_at(1, 0, 0, 1, 0, "R3");
    expect_at(1, 1, 0, 1, 0, "R3");
    expect_at(S, 0, 0, 1, 0, "R4");
    expect_at(S + 1, 0, 1, 1, 1, "R4");
    expect_at(S + 1, 1, 1, 1, 1, "R5");
    step(S + 4);

    // R9: short undervoltage glitch on pair 0
    uv_cmp[0] = 1'b0;
    expect_at(F + 3, 0, 1, 1, 1, "R9");
    expect_at(F + 8, 0, 1, 1, 1, "R9");
    step(F - 1);
    uv_cmp[0] = 1'b1;
    step(F + 12);

    // R6/R11: filtered undervoltage on pair 0
    uv_cmp[0] = 1'b0;
    expect_at(F + 2, 0, 1, 1, 1, "R6");
    expect_at(F + 3, 0, 0, 1, 0, "R6");
    expect_at(F + 3, 1, 1, 1, 1, "R11");
    step(F + 5);
    uv_cmp[0] = 1'b1;
    expect_at(S + 2, 0, 0, 1, 0, "R4");
    expect_at(S + 3, 0, 1, 1, 1, "R4");
    step(S + 5);

    // R7/R8/R11: overvoltage on pair 1
    ov_cmp[1] = 1'b1;
    expect_at(F + 2, 1, 1, 1, 1, "R7");
    expect_at(F + 3, 1, 1, 0, 0, "R7");
    expect_at(F + 3, 0, 1, 1, 1, "R11");
    step(F + 5);
    ov_cmp[1] = 1'b0;
    expect_at(F + 2, 1, 1, 0, 0, "R8");
    expect_at(F + 3, 1, 1, 1, 1, "R8");
    step(F + 5);

    // R9: short overvoltage glitch on pair 1
    ov_cmp[1] = 1'b1;
    expect_at(F + 3, 1, 1, 1, 1, "R9");
    expect_at(F + 8, 1, 1, 1, 1, "R9");
    step(F - 1);
    ov_cmp[1] = 1'b0;
    step(F + 12);

    // R10/R11: disable pair 0
    en[0] = 1'b0;
    expect_at(1, 0, 0, 0, 0, "R10");
    expect_at(1, 1, 1, 1, 1, "R11");
    step(10);
    expect_at(1, 0, 0, 0, 0, "R10");
    step(2);
    // Re-enable, then land an overvoltage flip on the stability edge
    en[0] = 1'b1;
    expect_at(1, 0, 0, 1, 0, "R10");
    expect_at(S, 0, 0, 1, 0, "R4");
    expect_at(S + 1, 0, 1, 0, 0, "R7");
    step(S - F - 2);
    ov_cmp[0] = 1'b1;
    step(F + 6);
    ov_cmp[0] = 1'b0;
    expect_at(F + 3, 0, 1, 1, 1, "R8");
    step(F + 5);

    // R2: bias drops
    bias_ok = 1'b0;
    expect_at(1, 0, 0, 0, 0, "R2");
    expect_at(1, 1, 0, 0, 0, "R2");
    expect_at(3, 1, 0, 0, 0, "R2");
    step(4);
    bias_ok = 1'b1;
    expect_at(S + 1, 1, 1, 1, 1, "R4");
    step(S + 4);

    // R1: reset from a running state
    rst = 1'b1;
    expect_at(1, 0, 0, 0, 0, "R1");
    expect_at(1, 1, 0, 0, 0, "R1");
    step(4);

    if (sbq.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d items unchecked, expected 0", sbq.size());
    end
    report();
  end
endmodule